// File: doc/BRIEF.md
# DMA Command-Queue Register Block

This block is the software-facing register file of a DMA engine's command queue. A host reaches it through a simple request bus. A request carries a valid strobe, a write flag, a byte address inside a 4 KiB window and a 32-bit data word. Every access covers one whole 32-bit word. The block stores the queue end pointer and the queue write pointer. It copies each written write pointer into a read-pointer register. It also holds an interrupt-enable register, a status register and a level interrupt output.

No data is moved. Each time software advances the write pointer, the block reports that all queued work is done: it sets the upstream and downstream completion bits in status in the same clock edge. A small one-shot state machine has two states, `OS_IDLE` and `OS_ARMED`. It moves `OS_IDLE -> OS_ARMED` when the read-pointer register is written with the key 0xEE882266. It moves `OS_ARMED -> OS_IDLE` on the next write-pointer write, and that write then produces no completion. A key write while already in `OS_ARMED` keeps it there.

The `LAYOUT` parameter picks one of two register arrangements. Layout 0 places the pointers at 0x14/0x18/0x1C, enable at 0x20, status at 0x24 and completion at bits 4 and 5. Layout 1 places the pointers at 0x18/0x1C/0x20, enable at 0x38, status at 0x3C and completion at bits 16 and 17.

Top module: `cmdq_regblk`

## Requirements
- R1: A read request returns the selected word on `rsp_rdata` at the clock edge that follows the request. The word is chosen by address bits 11:2, bits 1:0 are ignored, and `rsp_rdata` holds its value when no read is made.
- R2: After reset every register reads 0, except status, which reads 0xF8000000. The one-shot is in `OS_IDLE` and `irq` is low.
- R3: Writes to the end-pointer and write-pointer registers keep only bits 17:0 of the data (mask 0x0003FFFF).
- R4: A write-pointer write also loads the same masked value into the read-pointer register.
- R5: A write-pointer write made in `OS_IDLE` sets both completion status bits. These are bits 5:4 in layout 0 and bits 17:16 in layout 1.
- R6: Writing 0xEE882266 to the read-pointer register arms the one-shot and leaves that register unchanged. Any other value written there has no effect. An armed write-pointer write sets no completion bit and disarms, so exactly one completion is suppressed however many key writes preceded it.
- R7: A write to the interrupt-enable register stores the data ANDed with 0xBFEFF07F in layout 0 and with 0x017003FF in layout 1.
- R8: `irq` is high exactly when some completion status bit is set together with the enable bit in the same position. It changes on the same edge as the register write that causes the change.
- R9: A status write whose data has either completion bit set clears both completion bits. Software writes never change any other status bit, so bits 31:27 stay set.
- R10: Words in the span that are not named above are plain 32-bit read/write storage.
- R11: Addresses at or beyond word `NUM_WORDS` (byte 0x40 by default) read as zero, and writes to them change no register.
- R12: With `LAYOUT`=1 every register sits at its layout-1 offset, and its masks and completion bits apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level completion interrupt |

## Verification
The bound checker watches, on every cycle, the transitions of the one-shot state machine. It also checks that a key write arms, that an armed write-pointer write leaves the completion bits untouched, that an idle one sets them, and that the write pointer is mirrored. On every cycle it further checks that a clearing status write drops `irq`, that the fixed status bits stay set, and that out-of-span reads return zero. Only the bench's scenarios can show the bit masks applied to stored values and the read latency. The same holds for address aliasing past the span, a double key write still suppressing a single completion, `irq` following a later enable change, and the second layout's offsets.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int          DATA_W      = 32;
    localparam logic [31:0] PTR_MASK    = 32'h0003_FFFF;
    localparam logic [31:0] ARM_KEY     = 32'hEE88_2266;
    localparam logic [31:0] STAT_RESET  = 32'hF800_0000;

    typedef enum logic {
        OS_IDLE  = 1'b0,
        OS_ARMED = 1'b1
    } oneshot_state_e;

    function automatic int end_word(input int lay);
        return (lay == 0) ? 5 : 6;
    endfunction

    function automatic int wp_word(input int lay);
        return (lay == 0) ? 6 : 7;
    endfunction

    function automatic int rp_word(input int lay);
        return (lay == 0) ? 7 : 8;
    endfunction

    function automatic int ctrl_word(input int lay);
        return (lay == 0) ? 8 : 14;
    endfunction

    function automatic int stat_word(input int lay);
        return (lay == 0) ? 9 : 15;
    endfunction

    function automatic logic [31:0] ctrl_mask(input int lay);
        return (lay == 0) ? 32'hBFEF_F07F : 32'h0170_03FF;
    endfunction

    function automatic logic [31:0] comp_bits(input int lay);
        return (lay == 0) ? 32'h0000_0030 : 32'h0003_0000;
    endfunction

endpackage

// File: rtl/cmdq_oneshot_fsm.sv
module cmdq_oneshot_fsm
    import cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic consume,
    output logic armed,
    output logic suppress
);

    oneshot_state_e state_q;
    oneshot_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE:  if (arm)     state_d = OS_ARMED;
            OS_ARMED: if (consume) state_d = OS_IDLE;
            default:  state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        armed    = (state_q == OS_ARMED);
        suppress = (state_q == OS_ARMED) && consume;
    end

endmodule

// File: rtl/cmdq_irq_unit.sv
module cmdq_irq_unit
    import cmdq_pkg::*;
#(
    parameter int LAYOUT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic              complete,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] status_q,
    output logic              irq
);

    localparam logic [31:0] CMASK = ctrl_mask(LAYOUT);
    localparam logic [31:0] COMP  = comp_bits(LAYOUT);

    logic [DATA_W-1:0] ctrl_d;
    logic [DATA_W-1:0] status_d;
    logic              irq_d;

    always_comb begin
        ctrl_d   = ctrl_we ? (wdata & CMASK) : ctrl_q;
        status_d = status_q;
        if (complete)
            status_d = status_d | COMP;
        if (stat_we && ((wdata & COMP) != '0))
            status_d = status_d & ~COMP;
        irq_d = |(status_d & ctrl_d & COMP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            status_q <= STAT_RESET;
            irq      <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            status_q <= status_d;
            irq      <= irq_d;
        end
    end

endmodule

// File: rtl/cmdq_regstore.sv
module cmdq_regstore
    import cmdq_pkg::*;
#(
    parameter int LAYOUT    = 0,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] rp_q
);

    localparam int END_I  = end_word(LAYOUT);
    localparam int WP_I   = wp_word(LAYOUT);
    localparam int RP_I   = rp_word(LAYOUT);
    localparam int CTRL_I = ctrl_word(LAYOUT);
    localparam int STAT_I = stat_word(LAYOUT);

    logic [DATA_W-1:0] words [NUM_WORDS];
    logic              wp_hit;

    assign wp_hit = we && (int'(widx) == WP_I);

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] q;
        if (i == CTRL_I || i == STAT_I) begin : g_hole
            assign q = '0;
        end else if (i == RP_I) begin : g_mirror
            always_ff @(posedge clk) begin
                if (!rst_n)      q <= '0;
                else if (wp_hit) q <= wdata & PTR_MASK;
            end
        end else if (i == END_I || i == WP_I) begin : g_ptr
            always_ff @(posedge clk) begin
                if (!rst_n)                        q <= '0;
                else if (we && int'(widx) == i)    q <= wdata & PTR_MASK;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)                        q <= '0;
                else if (we && int'(widx) == i)    q <= wdata;
            end
        end
        assign words[i] = q;
    end

    assign rword = words[ridx];
    assign rp_q  = words[RP_I];

endmodule

// File: rtl/cmdq_regblk.sv
module cmdq_regblk
    import cmdq_pkg::*;
#(
    parameter int LAYOUT    = 0,
    parameter int NUM_WORDS = 16,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              irq
);

    localparam int IDX_W  = $clog2(NUM_WORDS);
    localparam int WP_I   = wp_word(LAYOUT);
    localparam int RP_I   = rp_word(LAYOUT);
    localparam int CTRL_I = ctrl_word(LAYOUT);
    localparam int STAT_I = stat_word(LAYOUT);

    logic [ADDR_W-3:0] full_idx;
    logic [IDX_W-1:0]  idx;
    logic              in_span;
    logic              wr_hit;
    logic              rd_hit;
    logic              wp_write;
    logic              key_write;
    logic              os_armed;
    logic              os_suppress;
    logic [31:0]       store_word;
    logic [31:0]       ctrl_q;
    logic [31:0]       status_q;
    logic [31:0]       rp_q;
    logic              unused_lsb;

    assign full_idx   = req_addr[ADDR_W-1:2];
    assign in_span    = (int'(full_idx) < NUM_WORDS);
    assign idx        = full_idx[IDX_W-1:0];
    assign unused_lsb = &{1'b0, req_addr[1:0]};
    assign wr_hit     = req_valid && req_write && in_span;
    assign rd_hit     = req_valid && !req_write;
    assign wp_write   = wr_hit && (int'(idx) == WP_I);
    assign key_write  = wr_hit && (int'(idx) == RP_I) && (req_wdata == ARM_KEY);

    cmdq_oneshot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (key_write),
        .consume  (wp_write),
        .armed    (os_armed),
        .suppress (os_suppress)
    );

    cmdq_regstore #(.LAYOUT(LAYOUT), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_hit),
        .widx  (idx),
        .wdata (req_wdata),
        .ridx  (idx),
        .rword (store_word),
        .rp_q  (rp_q)
    );

    cmdq_irq_unit #(.LAYOUT(LAYOUT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (wr_hit && int'(idx) == CTRL_I),
        .stat_we  (wr_hit && int'(idx) == STAT_I),
        .complete (wp_write && !os_suppress),
        .wdata    (req_wdata),
        .ctrl_q   (ctrl_q),
        .status_q (status_q),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (rd_hit) begin
            if (!in_span)                   rsp_rdata <= '0;
            else if (int'(idx) == CTRL_I)   rsp_rdata <= ctrl_q;
            else if (int'(idx) == STAT_I)   rsp_rdata <= status_q;
            else                            rsp_rdata <= store_word;
        end
    end

endmodule

// File: rtl/cmdq_regblk_chk.sv
module cmdq_regblk_chk
    import cmdq_pkg::*;
#(
    parameter int LAYOUT    = 0,
    parameter int NUM_WORDS = 16,
    parameter int ADDR_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rsp_rdata,
    input logic              irq,
    input logic [31:0]       status_q,
    input logic              os_armed,
    input logic [31:0]       rp_q
);

    localparam logic [31:0] COMP = comp_bits(LAYOUT);
    localparam int          WP_I = wp_word(LAYOUT);
    localparam int          RP_I = rp_word(LAYOUT);
    localparam int          ST_I = stat_word(LAYOUT);

    logic wr_wp, wr_key, wr_clr, rd_out;
    assign wr_wp  = req_valid && req_write && int'(req_addr[ADDR_W-1:2]) == WP_I;
    assign wr_key = req_valid && req_write && int'(req_addr[ADDR_W-1:2]) == RP_I
                    && req_wdata == ARM_KEY;
    assign wr_clr = req_valid && req_write && int'(req_addr[ADDR_W-1:2]) == ST_I
                    && (req_wdata & COMP) != '0;
    assign rd_out = req_valid && !req_write && int'(req_addr[ADDR_W-1:2]) >= NUM_WORDS;

    // R6: key write arms the one-shot
    a_r6_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
        wr_key |=> os_armed);

    // R6: armed write-pointer write disarms and leaves completion bits as they were
    a_r6_suppress_once: assert property (@(posedge clk) disable iff (!rst_n)
        (os_armed && wr_wp) |=> (!os_armed && ((status_q & COMP) == ($past(status_q) & COMP))));

    // R5: idle write-pointer write sets both completion bits
    a_r5_completion: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_armed && wr_wp) |=> ((status_q & COMP) == COMP));

    // R4: mirror of the masked write pointer
    a_r4_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        wr_wp |=> (rp_q == ($past(req_wdata) & PTR_MASK)));

    // R9: clearing write drops the interrupt
    a_r9_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> !irq);

    // R9: fixed status bits never change and no other bits appear
    a_r9_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~COMP) == STAT_RESET);

    // R11: out-of-span read returns zero
    a_r11_out_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |=> (rsp_rdata == '0));

endmodule

bind cmdq_regblk cmdq_regblk_chk #(
    .LAYOUT(LAYOUT), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .irq       (irq),
    .status_q  (status_q),
    .os_armed  (os_armed),
    .rp_q      (rp_q)
);

// File: tb/tb_cmdq_regblk.sv
`timescale 1ns/1ps
module tb_cmdq_regblk;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        v_a = 0, w_a = 0, v_b = 0, w_b = 0;
    logic [11:0] a_a = 0, a_b = 0;
    logic [31:0] d_a = 0, d_b = 0;
    logic [31:0] q_a, q_b;
    logic        irq_a, irq_b;

    cmdq_regblk #(.LAYOUT(0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(v_a), .req_write(w_a),
        .req_addr(a_a), .req_wdata(d_a), .rsp_rdata(q_a), .irq(irq_a));

    cmdq_regblk #(.LAYOUT(1)) dut_b (
        .clk(clk), .rst_n(rst_n), .req_valid(v_b), .req_write(w_b),
        .req_addr(a_b), .req_wdata(d_b), .rsp_rdata(q_b), .irq(irq_b));

    typedef struct {
        bit          on_b;
        logic [31:0] exp;
        int          cyc;
        string       tag;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares read responses one cycle after each request
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc < cyc) begin
            item_t it;
            logic [31:0] got;
            it = sb.pop_front();
            got = it.on_b ? q_b : q_a;
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic wr(input bit b, input logic [11:0] ad, input logic [31:0] dt);
        @(negedge clk);
        if (b) begin v_b = 1; w_b = 1; a_b = ad; d_b = dt; end
        else   begin v_a = 1; w_a = 1; a_a = ad; d_a = dt; end
        @(posedge clk); #1;
        v_a = 0; v_b = 0;
    endtask

    task automatic rd(input bit b, input logic [11:0] ad, input logic [31:0] ex, input string tag);
        item_t it;
        @(negedge clk);
        if (b) begin v_b = 1; w_b = 0; a_b = ad; end
        else   begin v_a = 1; w_a = 0; a_a = ad; end
        it.on_b = b; it.exp = ex; it.cyc = cyc; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
        v_a = 0; v_b = 0;
    endtask

    task automatic chk_irq(input bit b, input logic ex, input string tag);
        logic got;
        @(negedge clk);
        got = b ? irq_b : irq_a;
        checks++;
        if (got !== ex) begin
            fails++;
            $display("FAIL %s: irq got %b expected %b", tag, got, ex);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R2 reset state
        rd(0, 12'h024, 32'hF800_0000, "R2 status reset");
        rd(0, 12'h020, 32'h0, "R2 ctrl reset");
        rd(0, 12'h018, 32'h0, "R2 wp reset");
        chk_irq(0, 0, "R2 irq reset");
        // R3 end pointer mask
        wr(0, 12'h014, 32'hFFFF_FFFF);
        rd(0, 12'h014, 32'h0003_FFFF, "R3 end mask");
        // R7 ctrl mask
        wr(0, 12'h020, 32'hFFFF_FFFF);
        rd(0, 12'h020, 32'hBFEF_F07F, "R7 ctrl mask A");
        chk_irq(0, 0, "R8 no status yet");
        // R5 completion, R4 mirror, R1 alias
        wr(0, 12'h018, 32'hFFFF_1234);
        chk_irq(0, 1, "R8 irq on completion");
        rd(0, 12'h018, 32'h0003_1234, "R3 wp mask");
        rd(0, 12'h01C, 32'h0003_1234, "R4 mirror");
        rd(0, 12'h024, 32'hF800_0030, "R5 completion bits");
        rd(0, 12'h01B, 32'h0003_1234, "R1 low address bits ignored");
        // R9 W1C behaviour
        wr(0, 12'h024, 32'hFFFF_FFCF);
        rd(0, 12'h024, 32'hF800_0030, "R9 no comp bit no clear");
        chk_irq(0, 1, "R9 irq kept");
        wr(0, 12'h024, 32'h0000_0020);
        chk_irq(0, 0, "R9 irq dropped");
        rd(0, 12'h024, 32'hF800_0000, "R9 both cleared");
        wr(0, 12'h024, 32'h0);
        rd(0, 12'h024, 32'hF800_0000, "R9 fixed bits kept");
        // R6 one-shot
        wr(0, 12'h01C, 32'hEE88_2266);
        rd(0, 12'h01C, 32'h0003_1234, "R6 key leaves rp");
        wr(0, 12'h018, 32'h0000_0100);
        chk_irq(0, 0, "R6 suppressed irq");
        rd(0, 12'h024, 32'hF800_0000, "R6 suppressed status");
        rd(0, 12'h01C, 32'h0000_0100, "R4 mirror after suppress");
        wr(0, 12'h018, 32'h0000_0200);
        chk_irq(0, 1, "R6 only one suppressed");
        rd(0, 12'h024, 32'hF800_0030, "R6 second completes");
        wr(0, 12'h024, 32'h0000_0010);
        wr(0, 12'h01C, 32'h0000_0001);
        rd(0, 12'h01C, 32'h0000_0200, "R6 other value ignored");
        wr(0, 12'h018, 32'h0000_0300);
        rd(0, 12'h024, 32'hF800_0030, "R6 other value does not arm");
        wr(0, 12'h024, 32'h0000_0030);
        wr(0, 12'h01C, 32'hEE88_2266);
        wr(0, 12'h01C, 32'hEE88_2266);
        wr(0, 12'h018, 32'h0000_0005);
        rd(0, 12'h024, 32'hF800_0000, "R6 double key suppresses");
        wr(0, 12'h018, 32'h0000_0006);
        rd(0, 12'h024, 32'hF800_0030, "R6 double key single suppress");
        wr(0, 12'h024, 32'h0000_0010);
        // R8 enable gating
        wr(0, 12'h020, 32'h0);
        wr(0, 12'h018, 32'h0000_0007);
        chk_irq(0, 0, "R8 disabled no irq");
        wr(0, 12'h020, 32'h0000_0010);
        chk_irq(0, 1, "R8 late enable");
        wr(0, 12'h024, 32'h0000_0030);
        // R10 plain storage
        wr(0, 12'h000, 32'hA5A5_5A5A);
        rd(0, 12'h000, 32'hA5A5_5A5A, "R10 word0");
        wr(0, 12'h03C, 32'h1234_5678);
        rd(0, 12'h03C, 32'h1234_5678, "R10 word15");
        // R11 out of span
        wr(0, 12'h040, 32'hDEAD_BEEF);
        rd(0, 12'h040, 32'h0, "R11 read zero");
        rd(0, 12'hFFC, 32'h0, "R11 top of window");
        rd(0, 12'h000, 32'hA5A5_5A5A, "R11 write ignored");
        // R12 layout 1
        rd(1, 12'h03C, 32'hF800_0000, "R12 status reset");
        wr(1, 12'h038, 32'hFFFF_FFFF);
        rd(1, 12'h038, 32'h0170_03FF, "R12 R7 ctrl mask B");
        wr(1, 12'h018, 32'hFFFF_FFFF);
        rd(1, 12'h018, 32'h0003_FFFF, "R12 end mask");
        wr(1, 12'h01C, 32'hFFFF_FFFF);
        rd(1, 12'h020, 32'h0003_FFFF, "R12 mirror");
        rd(1, 12'h03C, 32'hF803_0000, "R12 R5 completion B");
        chk_irq(1, 0, "R12 R8 enable bits not writable");
        wr(1, 12'h03C, 32'h0001_0000);
        rd(1, 12'h03C, 32'hF800_0000, "R12 R9 clear B");
        wr(1, 12'h024, 32'h0BAD_F00D);
        rd(1, 12'h024, 32'h0BAD_F00D, "R12 R10 plain B");
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule